// File: doc/BRIEF.md
# Predicated Flag-Setting Execute Unit

This block is the execute stage of a small 32-bit integer pipeline. Each cycle it can accept one operation (move, add, subtract or compare) on two operands, where the second operand first passes through a barrel shifter that shifts it left with zero fill or right with sign fill. Every operation carries a condition code. The condition is tested against the status flags held inside the block, and an operation whose condition fails neither writes a result nor touches the flags.

The five status flags are negative, zero, carry, overflow and a sticky saturation bit. The flags change only on a compare, on an add, subtract or move that asks for a flag update, or on an explicit status write from outside. Results, the register-write strobe and the flags are registered, so an operation issued in one cycle reads the flags left by the operation issued in the cycle before it.

Top module: `condExecAlu`

## Requirements
- R1: While reset is held, and after it is released, `outValid` and `wrEn` read 0 and `flags` reads 5'b00000 until the first operation or status write.
- R2: Opcode 0 (move) writes the shifted second operand; shift type 0 is a left shift by `shiftAmt` (0 to 31) with zero fill.
- R3: Shift type 1 is a right shift by `shiftAmt` that copies bit 31 into the vacated bits.
- R4: Opcode 1 (add) writes A plus shifted B; with `setFlags` high it sets N to result bit 31, Z when the result is zero, C to the carry out of bit 31 and V when both addends share a sign that the result does not.
- R5: Opcode 2 (subtract) writes A minus shifted B; with `setFlags` high it sets N and Z from the result, C when no borrow occurs (A >= B unsigned) and V when the operands differ in sign and the result sign differs from A.
- R6: A move, add or subtract with `setFlags` low leaves all five flags unchanged; a move with `setFlags` high updates only N and Z.
- R7: Opcode 3 (compare) always updates N, Z, C, V as a subtraction would, and never raises `wrEn`.
- R8: Condition codes: 0 always, 1 when Z=1, 2 when Z=0, 3 when C=0 (unsigned lower), 4 when N differs from V (signed less than); codes 5 to 7 never pass.
- R9: An operation whose condition fails still raises `outValid` but gives `wrEn`=0 and leaves the flags unchanged.
- R10: Flags are ordered {N,Z,C,V,Q} from bit 4 down to bit 0; Q is changed only by a status write, which loads all five bits and takes priority over an operation's flag update in the same cycle.
- R11: Results, `wrEn`, `outValid` and flags appear one clock after the operation is presented, and a back-to-back operation is predicated on the flags left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | An operation is presented this cycle |
| opcode | input | 2 | 0 move, 1 add, 2 subtract, 3 compare |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand, before shifting |
| shiftType | input | 1 | 0 left shift, 1 sign-filling right shift |
| shiftAmt | input | 5 | Shift distance |
| setFlags | input | 1 | Update flags on move, add or subtract |
| condCode | input | 3 | Predicate selecting when the operation executes |
| statusWrEn | input | 1 | Load the flags from statusWrData |
| statusWrData | input | 5 | New flag value {N,Z,C,V,Q} |
| outValid | output | 1 | An operation finished in the previous cycle |
| wrEn | output | 1 | The result should be written back |
| result | output | 32 | Result of the last operation that wrote |
| flags | output | 5 | Current flags {N,Z,C,V,Q} |

## Verification
The assertions assume that a status write stands apart from flag-stability claims, so each flag-stability property is guarded by `statusWrEn` being low, and they take opcode and condition inputs as meaningful only while `inValid` is high. The stimulus keeps to this: status writes are issued with `inValid` low except in one deliberate priority case, idle cycles hold `inValid` low, and every operation drives defined operands, shift settings and condition code. Back-to-back sequences are chosen so that each compare sets up a known flag state for the predicated operation that follows.

// File: rtl/aluPkg.sv
package aluPkg;
  typedef enum logic [1:0] {OP_MOV = 2'd0, OP_ADD = 2'd1, OP_SUB = 2'd2, OP_CMP = 2'd3} aluOp_e;
  typedef enum logic {SH_LSL = 1'b0, SH_ASR = 1'b1} shiftKind_e;
  typedef enum logic [2:0] {
    CC_ALWAYS = 3'd0, CC_ZSET = 3'd1, CC_ZCLR = 3'd2, CC_ULOW = 3'd3, CC_SLESS = 3'd4
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
    logic q;
  } aluFlags_t;

  typedef struct packed {
    logic fire;       // an operation was presented
    logic writeRes;   // condition passed and result goes back
    logic updArith;   // N,Z,C,V take new values
    logic updLogic;   // only N,Z take new values
  } aluStrobe_t;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic      inValid,
  input  aluOp_e    opcode,
  input  logic      setFlags,
  input  logic [2:0] condCode,
  input  aluFlags_t flagsCur,
  output aluStrobe_t strobe
);
  logic condPass;

  always_comb begin
    unique case (condCode)
      CC_ALWAYS: condPass = 1'b1;
      CC_ZSET:   condPass = flagsCur.z;
      CC_ZCLR:   condPass = !flagsCur.z;
      CC_ULOW:   condPass = !flagsCur.c;
      CC_SLESS:  condPass = flagsCur.n ^ flagsCur.v;
      default:   condPass = 1'b0;
    endcase
  end

  logic go;
  assign go = inValid && condPass;

  always_comb begin
    strobe.fire     = inValid;
    strobe.writeRes = go && (opcode != OP_CMP);
    strobe.updArith = go && ((opcode == OP_CMP) ||
                             (setFlags && (opcode == OP_ADD || opcode == OP_SUB)));
    strobe.updLogic = go && setFlags && (opcode == OP_MOV);
  end

  // R8: never-codes cannot produce a write
  always_comb begin
    if (inValid && condCode > 3'd4)
      assert_never_code_R8: assert (!strobe.writeRes && !strobe.updArith && !strobe.updLogic);
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  shiftKind_e        shiftType,
  input  logic [SH_W-1:0]   shiftAmt,
  input  aluOp_e            opcode,
  input  aluStrobe_t        strobe,
  input  logic              statusWrEn,
  input  aluFlags_t         statusWrData,
  output aluFlags_t         flagsQ,
  output logic [DATA_W-1:0] resultQ,
  output logic              wrEnQ,
  output logic              validQ
);
  // Log-stage barrel shifter, one stage per bit of shiftAmt
  logic [SH_W:0][DATA_W-1:0] stage;
  assign stage[0] = opB;

  for (genvar i = 0; i < SH_W; i++) begin : gShift
    localparam int STEP = 1 << i;
    logic [DATA_W-1:0] leftVal, rightVal;
    assign leftVal  = {stage[i][DATA_W-1-STEP:0], {STEP{1'b0}}};
    assign rightVal = {{STEP{stage[i][DATA_W-1]}}, stage[i][DATA_W-1:STEP]};
    assign stage[i+1] = shiftAmt[i] ? ((shiftType == SH_ASR) ? rightVal : leftVal) : stage[i];
  end

  logic [DATA_W-1:0] shB;
  assign shB = stage[SH_W];

  // Shared adder: subtract as A + ~B + 1
  logic              isSub;
  logic [DATA_W-1:0] addB;
  logic [DATA_W:0]   sum;
  assign isSub = (opcode == OP_SUB) || (opcode == OP_CMP);
  assign addB  = isSub ? ~shB : shB;
  assign sum   = {1'b0, opA} + {1'b0, addB} + {{DATA_W{1'b0}}, isSub};

  logic [DATA_W-1:0] aluOut;
  logic              ovf;
  assign aluOut = (opcode == OP_MOV) ? shB : sum[DATA_W-1:0];
  assign ovf    = (opA[DATA_W-1] == addB[DATA_W-1]) && (sum[DATA_W-1] != opA[DATA_W-1]);

  aluFlags_t flagsNext;
  always_comb begin
    flagsNext = flagsQ;
    if (statusWrEn) begin
      flagsNext = statusWrData;
    end else if (strobe.updArith) begin
      flagsNext.n = aluOut[DATA_W-1];
      flagsNext.z = (aluOut == '0);
      flagsNext.c = sum[DATA_W];
      flagsNext.v = ovf;
    end else if (strobe.updLogic) begin
      flagsNext.n = aluOut[DATA_W-1];
      flagsNext.z = (aluOut == '0);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ  <= '0;
      resultQ <= '0;
      wrEnQ   <= 1'b0;
      validQ  <= 1'b0;
    end else begin
      flagsQ <= flagsNext;
      validQ <= strobe.fire;
      wrEnQ  <= strobe.writeRes;
      if (strobe.writeRes) resultQ <= aluOut;
    end
  end

  // R10: saturation bit is sticky without a status write
  assert_q_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!statusWrEn && flagsQ.q) |=> flagsQ.q);

  // R11: a write strobe only accompanies a completed operation
  assert_wr_needs_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrEnQ |-> validQ);
endmodule

// File: rtl/condExecAlu.sv
module condExecAlu
  import aluPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  opcode,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        shiftType,
  input  logic [4:0]  shiftAmt,
  input  logic        setFlags,
  input  logic [2:0]  condCode,
  input  logic        statusWrEn,
  input  logic [4:0]  statusWrData,
  output logic        outValid,
  output logic        wrEn,
  output logic [31:0] result,
  output logic [4:0]  flags
);
  aluStrobe_t strobe;
  aluFlags_t  flagsQ;

  aluControl u_control (
    .inValid  (inValid),
    .opcode   (aluOp_e'(opcode)),
    .setFlags (setFlags),
    .condCode (condCode),
    .flagsCur (flagsQ),
    .strobe   (strobe)
  );

  aluDatapath #(.DATA_W(32)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .opA          (opA),
    .opB          (opB),
    .shiftType    (shiftKind_e'(shiftType)),
    .shiftAmt     (shiftAmt),
    .opcode       (aluOp_e'(opcode)),
    .strobe       (strobe),
    .statusWrEn   (statusWrEn),
    .statusWrData (aluFlags_t'(statusWrData)),
    .flagsQ       (flagsQ),
    .resultQ      (result),
    .wrEnQ        (wrEn),
    .validQ       (outValid)
  );

  assign flags = flagsQ;

  // R7: compare never writes back
  assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 2'd3) |=> !wrEn);

  // R9: failing predicate leaves flags alone and writes nothing
  assert_fail_cond_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && condCode > 3'd4 && !statusWrEn) |=> (!wrEn && $stable(flags)));

  // R6: no flag request on non-compare keeps flags
  assert_no_flag_req_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !setFlags && opcode != 2'd3 && !statusWrEn) |=> $stable(flags));

  // R11: a presented operation completes on the next cycle
  assert_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
endmodule

// File: tb/test_condExecAlu.sv
`timescale 1ns/1ps
module test_condExecAlu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opcode = '0;
  logic [31:0] opA = '0, opB = '0;
  logic        shiftType = 1'b0;
  logic [4:0]  shiftAmt = '0;
  logic        setFlags = 1'b0;
  logic [2:0]  condCode = '0;
  logic        statusWrEn = 1'b0;
  logic [4:0]  statusWrData = '0;
  logic        outValid, wrEn;
  logic [31:0] result;
  logic [4:0]  flags;

  always #2.5 clk = ~clk;

  condExecAlu i_condExecAlu (.*);

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  // Scoreboard queues
  logic        qWr[$];
  logic [31:0] qRes[$];
  logic [4:0]  qFlg[$];
  string       qTag[$];

  logic [4:0] modelFlags = '0;   // {N,Z,C,V,Q}

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: compute expectation independently, push it, drive the operation
  task automatic issue(input string tag, input logic [1:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic st, input logic [4:0] amt,
                       input logic sf, input logic [2:0] cc,
                       input logic sw = 1'b0, input logic [4:0] swData = '0);
    logic [31:0] sh, res;
    logic pass, n, z, c, v;
    sh = st ? 32'($signed(b) >>> amt) : (b << amt);
    {n, z, c, v} = modelFlags[4:1];
    case (cc)
      3'd0: pass = 1'b1;
      3'd1: pass = z;
      3'd2: pass = !z;
      3'd3: pass = !c;
      3'd4: pass = (n != v);
      default: pass = 1'b0;
    endcase
    res = 32'h0;
    case (op)
      2'd0: res = sh;
      2'd1: {c, res} = {1'b0, a} + {1'b0, sh};
      default: res = a - sh;
    endcase
    if (op == 2'd1)      v = (a[31] == sh[31]) && (res[31] != a[31]);
    else if (op != 2'd0) begin
      c = (a >= sh);
      v = (a[31] != sh[31]) && (res[31] != a[31]);
    end
    if (sw) modelFlags = swData;
    else if (pass) begin
      if (op == 2'd3 || (sf && op != 2'd0))
        modelFlags = {res[31], res == 0, c, v, modelFlags[0]};
      else if (sf)
        modelFlags = {res[31], res == 0, modelFlags[2:0]};
    end
    qWr.push_back(pass && op != 2'd3);
    qRes.push_back(res);
    qFlg.push_back(modelFlags);
    qTag.push_back(tag);
    @(negedge clk);
    inValid = 1'b1; opcode = op; opA = a; opB = b; shiftType = st;
    shiftAmt = amt; setFlags = sf; condCode = cc;
    statusWrEn = sw; statusWrData = swData;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0; statusWrEn = 1'b0;
    end
  endtask

  task automatic statusWrite(input logic [4:0] d);
    @(negedge clk);
    inValid = 1'b0; statusWrEn = 1'b1; statusWrData = d;
    modelFlags = d;
  endtask

  // Monitor: pop and compare each completed operation
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (qWr.size() == 0) begin
        check("R11 unexpected outValid", 32'd1, 32'd0);
      end else begin
        logic ew; logic [31:0] er; logic [4:0] ef; string t;
        ew = qWr.pop_front(); er = qRes.pop_front();
        ef = qFlg.pop_front(); t = qTag.pop_front();
        check({t, " wrEn"}, {31'd0, wrEn}, {31'd0, ew});
        if (ew) check({t, " result"}, result, er);
        check({t, " flags"}, {27'd0, flags}, {27'd0, ef});
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outValid", {31'd0, outValid}, 32'd0);
    check("R1 wrEn", {31'd0, wrEn}, 32'd0);
    check("R1 flags", {27'd0, flags}, 32'd0);
    rstN = 1'b1;
    idle(2);
    check("R1 after release", {26'd0, outValid, flags}, 32'd0);

    issue("R2 move lsl", 2'd0, 0, 32'h0000_00A5, 0, 5'd8, 0, 3'd0);
    issue("R3 asr negative", 2'd0, 0, 32'h8000_0F00, 1, 5'd4, 0, 3'd0);
    issue("R3 asr positive", 2'd0, 0, 32'h7000_0000, 1, 5'd31, 0, 3'd0);
    issue("R6 add no flags", 2'd1, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 3'd0);
    issue("R4 add overflow", 2'd1, 32'h7FFF_FFFF, 32'd1, 0, 0, 1, 3'd0);
    issue("R4 add carry zero", 2'd1, 32'hFFFF_FFFF, 32'd1, 0, 0, 1, 3'd0);
    issue("R5 sub borrow", 2'd2, 32'd3, 32'd5, 0, 0, 1, 3'd0);
    issue("R5 sub signed ovf", 2'd2, 32'h8000_0000, 32'd1, 0, 0, 1, 3'd0);
    issue("R6 move setflags nz", 2'd0, 0, 32'd0, 0, 0, 1, 3'd0);
    issue("R7 cmp equal", 2'd3, 32'd9, 32'd9, 0, 0, 0, 3'd0);
    issue("R8 eq pass", 2'd1, 32'd1, 32'd2, 0, 0, 0, 3'd1);
    issue("R9 ne fails", 2'd1, 32'd1, 32'd2, 0, 0, 1, 3'd2);
    issue("R7 cmp lower", 2'd3, 32'd1, 32'd2, 0, 0, 0, 3'd0);
    issue("R8 cc pass", 2'd2, 32'd10, 32'd4, 0, 0, 0, 3'd3);
    issue("R8 ne pass", 2'd0, 0, 32'h55, 0, 0, 0, 3'd2);
    issue("R7 cmp signed", 2'd3, 32'hFFFF_FFFB, 32'd3, 0, 0, 0, 3'd0);
    issue("R8 lt pass", 2'd1, 32'd7, 32'd8, 0, 0, 0, 3'd4);
    issue("R9 never code", 2'd3, 32'd0, 32'd0, 0, 0, 1, 3'd6);
    issue("R9 eq fails", 2'd0, 0, 32'h77, 0, 0, 1, 3'd1);
    idle(2);
    statusWrite(5'b00001);
    issue("R10 q set kept", 2'd1, 32'd0, 32'd0, 0, 0, 1, 3'd0);
    issue("R10 q survives cmp", 2'd3, 32'd4, 32'd9, 0, 0, 0, 3'd0);
    issue("R10 status priority", 2'd1, 32'd1, 32'd1, 0, 0, 1, 3'd0, 1'b1, 5'b01100);
    issue("R8 lt fails", 2'd0, 0, 32'h1, 0, 0, 0, 3'd4);
    idle(2);
    statusWrite(5'b00000);
    issue("R10 q cleared", 2'd0, 0, 32'd3, 0, 0, 0, 3'd0);
    // R11: back-to-back pseudo-random mix
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]}; b = lfsr;
      issue("R11 mixed", b[1:0], a, b, b[2], a[4:0], a[5], 3'(b[9:7] % 5));
    end
    idle(3);
    check("R11 queue drained", qWr.size(), 32'd0);
    done = 1'b1;
    finishRun();
  end
endmodule